// File: doc/BRIEF.md
# Framebuffer Controller Register Bank

This block holds the software-visible configuration of a raster display framebuffer controller and drives it straight to the downstream timing generator and pixel fetch engine. A simple single-cycle bus reads and writes thirteen 32-bit words. Those words hold a control word, the horizontal and vertical active size, the sync edges, the line and frame totals, the framebuffer base, a read-only copy of that base, the fetch burst length and a pixel-clock setting. The byte address is shifted right by two to pick a word. Bits 1:0 of the address are ignored.

An access-outcome state machine records what the last bus cycle did, and during the next cycle it shows that outcome as one pulse. The states are `ST_IDLE` (no access), `ST_ACCEPT` (plain read or write), `ST_RESIZE` (a resolution write while enabled), `ST_REFRESH` (a base write that was accepted) and `ST_FAULT` (an access that was refused). On every clock the machine moves from its current state to the state that the current access selects. A write is classified first: refused goes to `ST_FAULT`, then base goes to `ST_REFRESH`, then resize goes to `ST_RESIZE`, and anything else goes to `ST_ACCEPT`. A read with no write goes to `ST_ACCEPT`, or to `ST_FAULT` when the address is unmapped. A cycle with no access goes to `ST_IDLE`.

Top module: `fbreg_bank`

## Requirements
- R1: The word index is bus_addr shifted right by two, and bits 1:0 are ignored. The index order is fixed: 0 control, 1 horizontal active, 2 hsync on, 3 hsync off, 4 horizontal total, 5 vertical active, 6 vsync on, 7 vsync off, 8 vertical total, 9 base, 10 base copy, 11 burst, 12 pixel clock. A read returns the last value stored at that index.
- R2: After reset every word is zero, except control, which reads 1, horizontal active, which reads 640, and vertical active, which reads 480. No pulse is raised during reset.
- R3: ctl_enable is high exactly while bit 0 of the control word is 0.
- R4: A write to index 9 with any of bits 4:0 set is discarded: fb_base is unchanged and err_pulse is raised.
- R5: An aligned write to index 9 stores the written value ANDed with ADDR_MASK and raises inval_pulse. fetch_addr always equals fb_base plus FB_OFFSET.
- R6: A read of index 10 returns the current base. A write to index 10 changes nothing and raises err_pulse.
- R7: A write to index 1 or 5 raises resize_pulse if ctl_enable was high in the cycle of the write. If ctl_enable was low, the value is stored and no resize_pulse is raised.
- R8: An access to any index of 13 or more changes no word, a read of it returns 0, and it raises err_pulse.
- R9: bus_rdata is registered: it shows the read word in the cycle after bus_re. It holds its value when there is no read, and also when bus_we and bus_re are both high, in which case only the write is performed.
- R10: resize_pulse, inval_pulse and err_pulse are high only in the cycle right after the access that causes them. At most one of them is high at a time, and all are low after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ctl_enable | output | 1 | Controller enable (soft reset clear) |
| h_active | output | DATA_W | Horizontal active pixels |
| h_sync_on | output | DATA_W | Horizontal sync start |
| h_sync_off | output | DATA_W | Horizontal sync end |
| h_total | output | DATA_W | Horizontal scan total |
| v_active | output | DATA_W | Vertical active lines |
| v_sync_on | output | DATA_W | Vertical sync start |
| v_sync_off | output | DATA_W | Vertical sync end |
| v_total | output | DATA_W | Vertical scan total |
| fb_base | output | DATA_W | Stored framebuffer base |
| fetch_addr | output | DATA_W | Base plus fixed offset for the fetch engine |
| burst_len | output | DATA_W | Fetch burst count |
| pix_clk_cfg | output | DATA_W | Pixel clock setting |
| resize_pulse | output | 1 | Resolution changed while enabled |
| inval_pulse | output | 1 | Base accepted, redraw needed |
| err_pulse | output | 1 | Refused or unmapped access |

## Verification
Every stored word is also a port, so a wrong write shows up on a configuration output, or on fetch_addr, by the first falling edge after the clock edge that stored it. A wrong outcome state shows up as a missing, extra or wrong pulse in the very next cycle. The random phase keeps a full model of all thirteen words after each access. Because of that, a bad decode cannot stay hidden behind later writes. The directed cases cover the enable-dependent resize, the alignment rejection and the read-only copy.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

    localparam int REG_COUNT = 13;
    localparam int IDX_W     = 4;

    // word indices; the order is the software-visible map
    localparam logic [IDX_W-1:0] IX_CTRL    = 4'd0;
    localparam logic [IDX_W-1:0] IX_HACT    = 4'd1;
    localparam logic [IDX_W-1:0] IX_HSON    = 4'd2;
    localparam logic [IDX_W-1:0] IX_HSOFF   = 4'd3;
    localparam logic [IDX_W-1:0] IX_HTOT    = 4'd4;
    localparam logic [IDX_W-1:0] IX_VACT    = 4'd5;
    localparam logic [IDX_W-1:0] IX_VSON    = 4'd6;
    localparam logic [IDX_W-1:0] IX_VSOFF   = 4'd7;
    localparam logic [IDX_W-1:0] IX_VTOT    = 4'd8;
    localparam logic [IDX_W-1:0] IX_BASE    = 4'd9;
    localparam logic [IDX_W-1:0] IX_BASE_RO = 4'd10;
    localparam logic [IDX_W-1:0] IX_BURST   = 4'd11;
    localparam logic [IDX_W-1:0] IX_PIXCLK  = 4'd12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_RESIZE,
        ST_REFRESH,
        ST_FAULT
    } acc_state_e;

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
    import fbreg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(REG_COUNT);

    logic [WORD_W-1:0] word;
    logic              unused_byte_lane;

    assign word             = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];
    assign hit              = (word < LIMIT);
    assign idx              = word[IDX_W-1:0];

endmodule

// File: rtl/fbreg_file.sv
module fbreg_file
    import fbreg_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] ADDR_MASK = '1,
    parameter logic [DATA_W-1:0] RST_HRES  = DATA_W'(640),
    parameter logic [DATA_W-1:0] RST_VRES  = DATA_W'(480)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [REG_COUNT-1:0][DATA_W-1:0] regs
);
    function automatic logic [DATA_W-1:0] reset_word(input int i);
        if (i == int'(IX_CTRL)) return DATA_W'(1);
        if (i == int'(IX_HACT)) return RST_HRES;
        if (i == int'(IX_VACT)) return RST_VRES;
        return '0;
    endfunction

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        if (g == int'(IX_BASE_RO)) begin : g_shadow
            // no storage: mirrors the base word
            assign regs[g] = regs[IX_BASE];
        end else begin : g_store
            localparam logic [DATA_W-1:0] RV   = reset_word(g);
            localparam logic [DATA_W-1:0] KEEP =
                (g == int'(IX_BASE)) ? ADDR_MASK : {DATA_W{1'b1}};
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RV;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    q <= wr_data & KEEP;
                end
            end
            assign regs[g] = q;
        end
    end

endmodule

// File: rtl/fbreg_seq.sv
module fbreg_seq
    import fbreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic re,
    input  logic hit,
    input  logic is_ro,
    input  logic is_base,
    input  logic base_bad,
    input  logic is_res,
    input  logic enabled,
    output logic resize_p,
    output logic inval_p,
    output logic err_p
);
    acc_state_e state, nxt;

    always_comb begin
        nxt = ST_IDLE;
        if (we) begin
            if (!hit || is_ro || base_bad) nxt = ST_FAULT;
            else if (is_base)              nxt = ST_REFRESH;
            else if (is_res && enabled)    nxt = ST_RESIZE;
            else                           nxt = ST_ACCEPT;
        end else if (re) begin
            nxt = hit ? ST_ACCEPT : ST_FAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        resize_p = 1'b0;
        inval_p  = 1'b0;
        err_p    = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_ACCEPT:  ;
            ST_RESIZE:  resize_p = 1'b1;
            ST_REFRESH: inval_p  = 1'b1;
            ST_FAULT:   err_p    = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/fbreg_bank.sv
module fbreg_bank
    import fbreg_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                ALIGN_LG2 = 5,
    parameter logic [DATA_W-1:0] ADDR_MASK = '1,
    parameter logic [DATA_W-1:0] FB_OFFSET = '0,
    parameter logic [DATA_W-1:0] RST_HRES  = DATA_W'(640),
    parameter logic [DATA_W-1:0] RST_VRES  = DATA_W'(480)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctl_enable,
    output logic [DATA_W-1:0] h_active,
    output logic [DATA_W-1:0] h_sync_on,
    output logic [DATA_W-1:0] h_sync_off,
    output logic [DATA_W-1:0] h_total,
    output logic [DATA_W-1:0] v_active,
    output logic [DATA_W-1:0] v_sync_on,
    output logic [DATA_W-1:0] v_sync_off,
    output logic [DATA_W-1:0] v_total,
    output logic [DATA_W-1:0] fb_base,
    output logic [DATA_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] burst_len,
    output logic [DATA_W-1:0] pix_clk_cfg,
    output logic              resize_pulse,
    output logic              inval_pulse,
    output logic              err_pulse
);
    logic [IDX_W-1:0]                 idx;
    logic                             hit;
    logic                             is_base, is_ro, is_res, base_bad, commit;
    logic [REG_COUNT-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]                rd_word;

    fbreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .idx  (idx),
        .hit  (hit)
    );

    assign is_base  = hit && (idx == IX_BASE);
    assign is_ro    = hit && (idx == IX_BASE_RO);
    assign is_res   = hit && ((idx == IX_HACT) || (idx == IX_VACT));
    assign base_bad = is_base && (|bus_wdata[ALIGN_LG2-1:0]);
    assign commit   = bus_we && hit && !is_ro && !base_bad;

    fbreg_file #(
        .DATA_W    (DATA_W),
        .ADDR_MASK (ADDR_MASK),
        .RST_HRES  (RST_HRES),
        .RST_VRES  (RST_VRES)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .regs    (regs)
    );

    fbreg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .re       (bus_re),
        .hit      (hit),
        .is_ro    (is_ro),
        .is_base  (is_base),
        .base_bad (base_bad),
        .is_res   (is_res),
        .enabled  (ctl_enable),
        .resize_p (resize_pulse),
        .inval_p  (inval_pulse),
        .err_p    (err_pulse)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (hit && idx == IDX_W'(i)) rd_word = regs[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_re && !bus_we)  bus_rdata <= rd_word;
    end

    assign ctl_enable  = !regs[IX_CTRL][0];
    assign h_active    = regs[IX_HACT];
    assign h_sync_on   = regs[IX_HSON];
    assign h_sync_off  = regs[IX_HSOFF];
    assign h_total     = regs[IX_HTOT];
    assign v_active    = regs[IX_VACT];
    assign v_sync_on   = regs[IX_VSON];
    assign v_sync_off  = regs[IX_VSOFF];
    assign v_total     = regs[IX_VTOT];
    assign fb_base     = regs[IX_BASE];
    assign fetch_addr  = regs[IX_BASE] + FB_OFFSET;
    assign burst_len   = regs[IX_BURST];
    assign pix_clk_cfg = regs[IX_PIXCLK];

endmodule

// File: rtl/fbreg_checker.sv
module fbreg_checker #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                ALIGN_LG2 = 5,
    parameter logic [DATA_W-1:0] ADDR_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-3:0] c_word,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ctl_enable,
    input logic [DATA_W-1:0] fb_base,
    input logic              resize_pulse,
    input logic              inval_pulse,
    input logic              err_pulse
);
    localparam int WW = ADDR_W - 2;

    logic hit_base, hit_ro, hit_res, hit_none, misal;
    assign hit_base = (c_word == WW'(9));
    assign hit_ro   = (c_word == WW'(10));
    assign hit_res  = (c_word == WW'(1)) || (c_word == WW'(5));
    assign hit_none = (c_word >= WW'(13));
    assign misal    = |bus_wdata[ALIGN_LG2-1:0];

    a_r3_enable_tracks_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && c_word == WW'(0)) |=> (ctl_enable == !$past(bus_wdata[0])));

    a_r4_misaligned_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_base && misal) |=> ($stable(fb_base) && err_pulse));

    a_r5_aligned_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_base && !misal) |=>
            ((fb_base == ($past(bus_wdata) & ADDR_MASK)) && inval_pulse));

    a_r6_copy_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ro) |=> ($stable(fb_base) && err_pulse));

    a_r7_resize_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_res && ctl_enable) |=> resize_pulse);

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_res && !ctl_enable) |=> !resize_pulse);

    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_none) |=> err_pulse);

    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_we && hit_none) |=> (err_pulse && bus_rdata == '0));

    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && !bus_we) |=> $stable(bus_rdata));

    a_r10_one_at_most: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resize_pulse, inval_pulse, err_pulse}));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !bus_re) |=> !(resize_pulse || inval_pulse || err_pulse));

endmodule

bind fbreg_bank fbreg_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ALIGN_LG2 (ALIGN_LG2),
    .ADDR_MASK (ADDR_MASK)
) u_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .c_word       (bus_addr[ADDR_W-1:2]),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ctl_enable   (ctl_enable),
    .fb_base      (fb_base),
    .resize_pulse (resize_pulse),
    .inval_pulse  (inval_pulse),
    .err_pulse    (err_pulse)
);

// File: tb/test_fbreg_bank.sv
`timescale 1ns/1ps
module test_fbreg_bank;
    localparam logic [31:0] MASK = 32'h0FFF_FFFF;
    localparam logic [31:0] OFS  = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata, h_active, h_sync_on, h_sync_off, h_total;
    logic [31:0] v_active, v_sync_on, v_sync_off, v_total, fb_base;
    logic [31:0] fetch_addr, burst_len, pix_clk_cfg;
    logic        ctl_enable, resize_pulse, inval_pulse, err_pulse;

    always #2.5 clk = ~clk;

    fbreg_bank #(.ADDR_MASK(MASK), .FB_OFFSET(OFS)) i_fbreg_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_enable(ctl_enable), .h_active(h_active), .h_sync_on(h_sync_on),
        .h_sync_off(h_sync_off), .h_total(h_total), .v_active(v_active),
        .v_sync_on(v_sync_on), .v_sync_off(v_sync_off), .v_total(v_total),
        .fb_base(fb_base), .fetch_addr(fetch_addr), .burst_len(burst_len),
        .pix_clk_cfg(pix_clk_cfg), .resize_pulse(resize_pulse),
        .inval_pulse(inval_pulse), .err_pulse(err_pulse));

    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [31:0] mdl [13];
    logic [31:0] last_rd = '0;

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] exp_outs();
        return {mdl[0][0] == 1'b0, mdl[1], mdl[2], mdl[3], mdl[4], mdl[5], mdl[6],
                mdl[7], mdl[8], mdl[9], mdl[9] + OFS, mdl[11], mdl[12]};
    endfunction

    function automatic logic [511:0] act_outs();
        return {ctl_enable, h_active, h_sync_on, h_sync_off, h_total, v_active,
                v_sync_on, v_sync_off, v_total, fb_base, fetch_addr, burst_len, pix_clk_cfg};
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        logic [29:0] w = a[31:2];
        if (w >= 30'd13) return '0;
        if (w == 30'd10) return mdl[9];
        return mdl[w[3:0]];
    endfunction

    // expected {resize, inval, err} of a write; updates the model
    function automatic logic [2:0] model_write(input logic [31:0] a, input logic [31:0] d);
        logic [29:0] w = a[31:2];
        if (w >= 30'd13 || w == 30'd10) return 3'b001;
        if (w == 30'd9) begin
            if (d[4:0] != 5'd0) return 3'b001;
            mdl[9] = d & MASK;
            return 3'b010;
        end
        if (w == 30'd1 || w == 30'd5) begin
            logic en = (mdl[0][0] == 1'b0);
            mdl[w[3:0]] = d;
            return en ? 3'b100 : 3'b000;
        end
        mdl[w[3:0]] = d;
        return 3'b000;
    endfunction

    task automatic do_write(input string req, input logic [31:0] a, input logic [31:0] d);
        logic [2:0] ep;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        ep = model_write(a, d);
        @(posedge clk); #1 bus_we = 1'b0;
        @(negedge clk);
        chk({req, " pulses"}, 512'({resize_pulse, inval_pulse, err_pulse}), 512'(ep));
        chk({req, " outputs"}, act_outs(), exp_outs());
    endtask

    task automatic do_read(input string req, input logic [31:0] a);
        logic [31:0] er;
        logic        ee;
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        er = exp_read(a); ee = (a[31:2] >= 30'd13);
        @(posedge clk); #1 bus_re = 1'b0;
        @(negedge clk);
        last_rd = er;
        chk({req, " rdata"}, 512'(bus_rdata), 512'(er));
        chk({req, " pulses"}, 512'({resize_pulse, inval_pulse, err_pulse}), 512'({2'b00, ee}));
    endtask

    task automatic do_both(input logic [31:0] a, input logic [31:0] d);
        logic [2:0] ep;
        @(negedge clk);
        bus_we = 1'b1; bus_re = 1'b1; bus_addr = a; bus_wdata = d;
        ep = model_write(a, d);
        @(posedge clk); #1 bus_we = 1'b0; bus_re = 1'b0;
        @(negedge clk);
        chk("R9 write-wins rdata held", 512'(bus_rdata), 512'(last_rd));
        chk("R9 write-wins pulses", 512'({resize_pulse, inval_pulse, err_pulse}), 512'(ep));
        chk("R9 write-wins outputs", act_outs(), exp_outs());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd7741);
        for (int i = 0; i < 13; i++) mdl[i] = '0;
        mdl[0] = 32'd1; mdl[1] = 32'd640; mdl[5] = 32'd480;
        repeat (3) @(negedge clk);
        chk("R2 reset outputs", act_outs(), exp_outs());
        chk("R2 reset pulses", 512'({resize_pulse, inval_pulse, err_pulse}), 512'(0));
        rst_n = 1'b1;
        for (int i = 0; i < 13; i++) do_read("R1 R2 reset readback", 32'(i * 4));

        do_write("R7 resize while disabled", 32'h04, 32'd800);
        do_write("R3 clear soft reset", 32'h00, 32'h0);
        chk("R3 enable high", 512'(ctl_enable), 512'(1));
        do_write("R7 hres while enabled", 32'h04, 32'd1024);
        do_write("R7 vres while enabled", 32'h14, 32'd768);
        do_write("R4 misaligned base", 32'h24, 32'h0000_2011);
        do_write("R4 misaligned base bit4", 32'h24, 32'h0000_3010);
        do_write("R5 aligned masked base", 32'h24, 32'hF000_1240);
        chk("R5 fetch address", 512'(fetch_addr), 512'(32'h0000_1640));
        do_read("R6 copy read", 32'h28);
        do_write("R6 copy write refused", 32'h28, 32'h0000_5000);
        do_read("R8 unmapped read", 32'h40);
        do_write("R8 unmapped write", 32'h34, 32'hDEAD_BEEF);
        do_write("R8 high address bit", 32'h8000_0024, 32'h0000_0040);
        do_write("R1 low address bits ignored", 32'h0000_000F, 32'h0000_0123);
        do_read("R1 readback hsync off", 32'h0C);
        do_read("R9 read hres", 32'h04);
        @(negedge clk);
        chk("R9 rdata holds idle", 512'(bus_rdata), 512'(last_rd));
        chk("R10 idle no pulse", 512'({resize_pulse, inval_pulse, err_pulse}), 512'(0));
        do_both(32'h08, 32'h0000_0777);
        do_write("R3 set soft reset", 32'h00, 32'h0000_0003);
        chk("R3 enable low", 512'(ctl_enable), 512'(0));

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, d;
            a = {26'd0, 4'($urandom % 15), 2'($urandom)};
            if ($urandom % 10 == 0) a[31:20] = 12'($urandom);
            d = $urandom;
            if ($urandom % 2 == 0) d[4:0] = 5'd0;
            if ($urandom % 8 == 0) begin
                a = 32'h0; d = {31'($urandom), 1'($urandom)};
            end
            if ($urandom % 2 == 0) do_write("R1 R5 R7 R8 random write", a, d);
            else                   do_read("R1 R6 R8 random read", a);
        end
        finish_run();
    end
endmodule